// File: doc/BRIEF.md
# Arithmetic Unit with Held Comparison Flags

This block is the arithmetic core of a small single-accumulator processor. It takes a working-register operand and a memory operand, computes every supported operation side by side, and passes one of those results to its output through a multiplexor driven by a three-bit operation code. The result path is purely combinational, so the output follows the inputs within the same cycle.

Next to the result path sits a three-bit flag register holding greater, equal and less indications. The register is written only when a compare is requested while the enable is high. It then holds its value across any number of other operations, so that a later conditional branch in the surrounding sequencer can test it. Instruction sequencing, memory access and branch-target handling belong to the surrounding design.

The operands are two's complement words of `W` bits. Arithmetic wraps modulo 2^W.

Top module: `alu_cc_unit`

## Requirements
- R1: Operation code 0 (clear) drives `res_o` to all zeros, whatever the operands are.
- R2: Operation code 1 (add) drives `res_o` to `acc_i + mem_i` modulo 2^W.
- R3: Operation code 2 (subtract) drives `res_o` to `acc_i - mem_i` modulo 2^W.
- R4: Operation code 3 (increment) drives `res_o` to `mem_i + 1` modulo 2^W.
- R5: Operation code 4 (decrement) drives `res_o` to `mem_i - 1` modulo 2^W.
- R6: Operation code 5 (compare) drives `res_o` to `mem_i`. When `en_i` is high at a rising clock edge, the flags update at that edge to a one-hot value. Bit 2 (greater) is set when `mem_i > acc_i`, bit 1 (equal) is set when they are equal, and bit 0 (less) is set when `mem_i < acc_i`. Both operands are read as signed two's complement numbers.
- R7: Operation code 6 drives `res_o` to `mem_i`, and operation code 7 drives `res_o` to `acc_i`.
- R8: `flags_o` keeps its value across a clock edge when the operation code is not 5 or when `en_i` is low.
- R9: An active-low `rst_n` clears `flags_o` to 3'b000 at once, and it stays at 3'b000 while reset is held.
- R10: `flags_o` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flags update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| en_i | input | 1 | Allows a compare to write the flags |
| op_i | input | 3 | Operation code; the values are listed in R1 to R7 |
| acc_i | input | W | Working-register operand |
| mem_i | input | W | Memory operand |
| res_o | output | W | Selected result word |
| flags_o | output | 3 | Held flags: bit 2 greater, bit 1 equal, bit 0 less |

## Verification
The bench builds the block with the default width of 16 bits. At this width it can reach the exact wrap points 7FFF, 8000 and FFFF with hand-picked vectors. It also covers compares in which the operands differ in sign, where an unsigned comparison would give the wrong answer. After the vector table and the sign-crossing compares, random operand pairs run every operation code against a reference model. In that run the bench checks that the flags hold whenever a compare is absent or the enable is low.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

  typedef enum logic [2:0] {
    OP_CLR = 3'd0,
    OP_ADD = 3'd1,
    OP_SUB = 3'd2,
    OP_INC = 3'd3,
    OP_DEC = 3'd4,
    OP_CMP = 3'd5,
    OP_LDM = 3'd6,
    OP_LDA = 3'd7
  } alu_op_e;

  localparam int unsigned NUM_OPS = 8;
  localparam int unsigned SEL_W   = $clog2(NUM_OPS);

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } cc_t;

endpackage

// File: rtl/alu_cc_lanes.sv
module alu_cc_lanes
  import alu_cc_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]              acc,
  input  logic [W-1:0]              mem,
  output logic [NUM_OPS-1:0][W-1:0] lane
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    lane           = '0;
    lane[OP_CLR]   = '0;
    lane[OP_ADD]   = acc + mem;
    lane[OP_SUB]   = acc - mem;
    lane[OP_INC]   = mem + ONE;
    lane[OP_DEC]   = mem - ONE;
    lane[OP_CMP]   = mem;
    lane[OP_LDM]   = mem;
    lane[OP_LDA]   = acc;
  end
endmodule

// File: rtl/alu_cc_mux.sv
module alu_cc_mux #(
  parameter int unsigned W = 16,
  parameter int unsigned N = 8,
  localparam int unsigned SW = $clog2(N)
) (
  input  logic [N-1:0][W-1:0] lane,
  input  logic [SW-1:0]       sel,
  output logic [W-1:0]        y
);
  logic [N-1:0][W-1:0] gated;

  // decoded one-hot select, then wide OR: one AND-OR level per bit
  for (genvar i = 0; i < N; i++) begin : g_gate
    logic hit;
    assign hit      = (sel == SW'(i));
    assign gated[i] = lane[i] & {W{hit}};
  end

  always_comb begin
    y = '0;
    for (int i = 0; i < N; i++) y = y | gated[i];
  end
endmodule

// File: rtl/alu_cc_ccreg.sv
module alu_cc_ccreg
  import alu_cc_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] mem,
  output cc_t          cc
);
  cc_t nxt;

  always_comb begin
    nxt.gt = $signed(mem) >  $signed(acc);
    nxt.eq = (mem == acc);
    nxt.lt = $signed(mem) <  $signed(acc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cc <= '0;
    else if (load) cc <= nxt;
  end
endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
  import alu_cc_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] mem_i,
  output logic [W-1:0] res_o,
  output logic [2:0]   flags_o
);
  logic [NUM_OPS-1:0][W-1:0] lane;
  alu_op_e op_e;
  logic    cc_load;
  cc_t     cc;

  assign op_e    = alu_op_e'(op_i);
  assign cc_load = en_i && (op_e == OP_CMP);

  alu_cc_lanes #(.W(W)) u_lanes (
    .acc  (acc_i),
    .mem  (mem_i),
    .lane (lane)
  );

  alu_cc_mux #(.W(W), .N(NUM_OPS)) u_mux (
    .lane (lane),
    .sel  (op_i),
    .y    (res_o)
  );

  alu_cc_ccreg #(.W(W)) u_cc (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cc_load),
    .acc   (acc_i),
    .mem   (mem_i),
    .cc    (cc)
  );

  assign flags_o = cc;
endmodule

// File: rtl/alu_cc_unit_chk.sv
module alu_cc_unit_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] acc_i,
  input logic [W-1:0] mem_i,
  input logic [W-1:0] res_o,
  input logic [2:0]   flags_o
);
  logic did_cmp;
  assign did_cmp = rst_n && en_i && (op_i == 3'd5);

  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd0) |-> (res_o == '0));

  p_pass_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd7) |-> (res_o == acc_i));

  p_cmp_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(did_cmp) |-> ($countones(flags_o) == 1));

  p_cmp_gt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(did_cmp) |-> (flags_o[2] == ($signed($past(mem_i)) > $signed($past(acc_i)))));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(did_cmp)) |-> $stable(flags_o));

  p_at_most_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(flags_o) <= 1);

  p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (flags_o == 3'b000 || $past(did_cmp)));
endmodule

bind alu_cc_unit alu_cc_unit_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en_i    (en_i),
  .op_i    (op_i),
  .acc_i   (acc_i),
  .mem_i   (mem_i),
  .res_o   (res_o),
  .flags_o (flags_o)
);

// File: tb/alu_cc_unit_bench.sv
`timescale 1ns/1ps
module alu_cc_unit_bench;
  localparam int W = 16;
  localparam int NV = 14;
  // {op, acc, mem, expected result}
  localparam logic [50:0] VEC [NV] = '{
    {3'd0, 16'h1234, 16'h5678, 16'h0000},
    {3'd1, 16'h0001, 16'h0002, 16'h0003},
    {3'd1, 16'hFFFF, 16'h0001, 16'h0000},
    {3'd1, 16'h7FFF, 16'h0001, 16'h8000},
    {3'd2, 16'h0005, 16'h0003, 16'h0002},
    {3'd2, 16'h0000, 16'h0001, 16'hFFFF},
    {3'd2, 16'h8000, 16'h0001, 16'h7FFF},
    {3'd3, 16'h1111, 16'hFFFF, 16'h0000},
    {3'd3, 16'h1111, 16'h00FF, 16'h0100},
    {3'd4, 16'h2222, 16'h0000, 16'hFFFF},
    {3'd4, 16'h2222, 16'h8000, 16'h7FFF},
    {3'd5, 16'h0001, 16'h0002, 16'h0002},
    {3'd6, 16'hAAAA, 16'h5555, 16'h5555},
    {3'd7, 16'hAAAA, 16'h5555, 16'hAAAA}
  };

  logic clk = 0, rst_n = 0, en_i = 0;
  logic [2:0] op_i = 0;
  logic [W-1:0] acc_i = 0, mem_i = 0, res_o;
  logic [2:0] flags_o;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [2:0] exp_f;

  always #5 clk = ~clk;

  alu_cc_unit #(.W(W)) u_alu_cc_unit (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .op_i(op_i),
    .acc_i(acc_i), .mem_i(mem_i), .res_o(res_o), .flags_o(flags_o)
  );

  function automatic string tag_of(logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [W-1:0] model(logic [2:0] op, logic [W-1:0] a, logic [W-1:0] m);
    case (op)
      3'd0: return '0;
      3'd1: return W'(a + m);
      3'd2: return W'(a - m);
      3'd3: return W'(m + 1);
      3'd4: return W'(m - 1);
      3'd7: return a;
      default: return m;
    endcase
  endfunction

  function automatic logic [2:0] cmp_model(logic [W-1:0] a, logic [W-1:0] m);
    if ($signed(m) > $signed(a)) return 3'b100;
    if (m == a) return 3'b010;
    return 3'b001;
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, clock one edge, sample flags at next negedge
  task automatic step(logic en, logic [2:0] op, logic [W-1:0] a, logic [W-1:0] m);
    en_i = en; op_i = op; acc_i = a; mem_i = m;
    #1;
    chk(tag_of(op), res_o, model(op, a, m));
    if (en && op == 3'd5) exp_f = cmp_model(a, m);
    @(negedge clk);
    chk((en && op == 3'd5) ? "R6" : "R8", W'(flags_o), W'(exp_f));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    exp_f = 3'b000;
    repeat (3) @(negedge clk);
    chk("R9", W'(flags_o), 16'h0000);
    rst_n = 1;
    @(negedge clk);

    // vector table, flag updates disabled: also covers R8 with en low
    for (int i = 0; i < NV; i++) begin
      step(1'b0, VEC[i][50:48], VEC[i][47:32], VEC[i][31:16]);
      chk(tag_of(VEC[i][50:48]), model(VEC[i][50:48], VEC[i][47:32], VEC[i][31:16]), VEC[i][15:0]);
    end

    // R6 compares including sign crossing
    step(1'b1, 3'd5, 16'h0001, 16'h0002);
    step(1'b1, 3'd5, 16'h0001, 16'h8000);
    step(1'b1, 3'd5, 16'hFFFF, 16'h0001);
    step(1'b1, 3'd5, 16'h4321, 16'h4321);
    // R8: add with enable high leaves flags; compare with enable low too
    step(1'b1, 3'd1, 16'h0003, 16'h0009);
    step(1'b0, 3'd5, 16'h0000, 16'h7FFF);
    // R10 checked across random run by the one-hot model
    for (int k = 0; k < 400; k++) begin
      logic [2:0] o;
      logic [W-1:0] a, m;
      o = 3'($urandom);
      a = W'($urandom);
      m = (k % 5 == 0) ? a : W'($urandom);
      step(1'($urandom), o, a, m);
      checks++;
      if ($countones(flags_o) > 1) begin
        fails++;
        $display("FAIL R10: got %b expected at most one bit", flags_o);
      end
    end

    // R9: reset mid-run clears flags at once
    step(1'b1, 3'd5, 16'h0000, 16'h0005);
    #2 rst_n = 0; #1;
    chk("R9", W'(flags_o), 16'h0000);
    exp_f = 3'b000;
    @(negedge clk);
    chk("R9", W'(flags_o), 16'h0000);
    rst_n = 1;
    @(negedge clk);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule